// File: doc/BRIEF.md
# I/O Page Translation Lookup

This block turns a DMA bus address into a physical page address by indexing a table of translation entries held in flip-flops inside the block. The table holds one entry per I/O page, and the page size is set by a shift parameter. A master presents an address together with a read/write flag. One cycle later the block returns five things: the input address aligned to its page, the translated page address, the in-page offset mask, the two-bit access permission, and a verdict on whether the access is allowed.

Software loads entries through a one-entry-per-cycle write port. A reset clears every entry, so every page faults until it has been programmed. If a lookup falls past the end of the table, the block does not signal an error. It returns no permission, zero addresses and an all-ones mask, and the access is denied.

Top module: `iommu_xlat_top`

## Requirements
- R1: A reset clears every table entry to zero. After a reset, a lookup of a page that was programmed before the reset returns permission 0, translated address 0, and is denied.
- R2: A request accepted on a clock edge produces `rsp_valid` high for exactly the following cycle. `rsp_valid` is low when no request was accepted on the previous edge.
- R3: `rsp_perm` carries bits [1:0] of the entry, encoded as 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R4: `rsp_paddr` equals the entry with its low PAGE_SHIFT bits cleared.
- R5: `rsp_iova` equals the request address with its low PAGE_SHIFT bits cleared. `rsp_mask` equals 2^PAGE_SHIFT - 1.
- R6: Only a page index (address >> PAGE_SHIFT) below NUM_ENTRIES is looked up. A larger index, including one whose low bits alias a valid entry, returns permission 0, `rsp_iova` 0, `rsp_paddr` 0, an all-ones `rsp_mask`, and is denied. Index NUM_ENTRIES-1 is still in range.
- R7: `rsp_deny` is high when a write finds permission bit 1 clear, or when a read finds permission bit 0 clear. `rsp_grant` is high exactly when `rsp_valid` is high and `rsp_deny` is low.
- R8: When a table write and a lookup target the same index in the same cycle, the write takes effect and the lookup returns the newly written value.
- R9: A table write changes only the entry it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the table |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | DMA bus address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| tbl_wr_en | input | 1 | Table entry write strobe |
| tbl_wr_idx | input | IDX_W | Entry index to write |
| tbl_wr_data | input | PA_W | Entry value: page address plus permission in bits [1:0] |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_iova | output | ADDR_W | Page-aligned request address |
| rsp_paddr | output | PA_W | Translated page address |
| rsp_mask | output | ADDR_W | In-page offset mask |
| rsp_perm | output | 2 | Access permission code |
| rsp_deny | output | 1 | The access does not match the permission |
| rsp_grant | output | 1 | Valid and permitted access |

## Verification
The hardest case to reach from the ports is a table write and a lookup on the same index in the same cycle. The bench sets up this collision by driving both strobes on the same clock edge, with an old value already stored in that entry. It then checks that the new value comes back, both on the colliding lookup and on a later one. A second hard case is an address whose page index is past the table but whose low index bits alias a programmed read-write entry. The bench loads entry 0 first, so a wrongly truncated index would show up as a granted access.

// File: rtl/iommu_xlat_pkg.sv
// Package: shared permission encoding for the page translation lookup.
// Assumes the permission sits in the two lowest bits of each table entry.
package iommu_xlat_pkg;
    typedef enum logic [1:0] {
        PERM_NONE  = 2'd0,
        PERM_READ  = 2'd1,
        PERM_WRITE = 2'd2,
        PERM_RDWR  = 2'd3
    } perm_e;
endpackage

// File: rtl/xlat_table.sv
// Module: xlat_table
// Entry storage with one write port and one registered read port.
// Assumes: reset clears every entry in one cycle (flop-based storage).
// A write to the read index in the same cycle is forwarded to the read.
// Writes to indices at or above NUM_ENTRIES are dropped.
module xlat_table #(
    parameter int NUM_ENTRIES = 48,
    parameter int PA_W        = 32,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_data
);
    logic [PA_W-1:0] mem [NUM_ENTRIES];
    logic            wr_ok;
    logic            rd_ok;

    assign wr_ok = wr_en && (32'(wr_idx) < NUM_ENTRIES);
    assign rd_ok = rd_en && (32'(rd_idx) < NUM_ENTRIES);

    // Purpose: clear on reset, otherwise store the written entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Purpose: registered read, with a same-index write taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_ok) begin
            rd_data <= (wr_ok && wr_idx == rd_idx) ? wr_data : mem[rd_idx];
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> mem[$past(wr_idx)] == $past(wr_data)); // R9

    AST_COLLIDE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && wr_ok && wr_idx == rd_idx) |=> rd_data == $past(wr_data)); // R8
endmodule

// File: rtl/xlat_perm_check.sv
// Module: xlat_perm_check
// Compares the direction of an access with the permission code.
// Assumes: the code follows iommu_xlat_pkg::perm_e.
// A read needs bit 0 set and a write needs bit 1 set.
module xlat_perm_check
    import iommu_xlat_pkg::*;
(
    input  logic       valid,
    input  logic       is_write,
    input  logic [1:0] perm,
    output logic       deny,
    output logic       grant
);
    logic allowed;

    // Purpose: decide whether the permission covers this access direction.
    always_comb begin
        unique case (perm_e'(perm))
            PERM_NONE:  allowed = 1'b0;
            PERM_READ:  allowed = !is_write;
            PERM_WRITE: allowed = is_write;
            PERM_RDWR:  allowed = 1'b1;
            default:    allowed = 1'b0;
        endcase
    end

    assign deny  = valid && !allowed;
    assign grant = valid && allowed;
endmodule

// File: rtl/iommu_xlat_top.sv
// Module: iommu_xlat_top
// Translates a DMA bus address via a per-page entry table, one-cycle latency.
// Assumes: PAGE_SHIFT >= 2 so the permission bits lie inside the page offset.
// Requests past the table return no permission and an all-ones mask.
module iommu_xlat_top
    import iommu_xlat_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PA_W        = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int NUM_ENTRIES = 48,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_idx,
    input  logic [PA_W-1:0]   tbl_wr_data,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_iova,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [ADDR_W-1:0] rsp_mask,
    output logic [1:0]        rsp_perm,
    output logic              rsp_deny,
    output logic              rsp_grant
);
    localparam int PN_W = ADDR_W - PAGE_SHIFT;
    localparam logic [ADDR_W-1:0] OFS_MASK_A = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);
    localparam logic [PA_W-1:0]   OFS_MASK_P = PA_W'((64'd1 << PAGE_SHIFT) - 64'd1);

    logic [PN_W-1:0]   page_num;
    logic              in_range;
    logic [IDX_W-1:0]  look_idx;
    logic [PA_W-1:0]   entry_q;
    logic              valid_q;
    logic              write_q;
    logic              in_range_q;
    logic [ADDR_W-1:0] addr_q;

    assign page_num = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign in_range = (64'(page_num) < 64'(NUM_ENTRIES));
    assign look_idx = page_num[IDX_W-1:0];

    xlat_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .PA_W        (PA_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_data (tbl_wr_data),
        .rd_en   (req_valid && in_range),
        .rd_idx  (look_idx),
        .rd_data (entry_q)
    );

    // Purpose: hold the request attributes alongside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            write_q    <= 1'b0;
            in_range_q <= 1'b0;
            addr_q     <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                write_q    <= req_write;
                in_range_q <= in_range;
                addr_q     <= req_addr;
            end
        end
    end

    // Purpose: form the response fields, forcing the out-of-range result.
    always_comb begin
        if (in_range_q) begin
            rsp_iova  = addr_q & ~OFS_MASK_A;
            rsp_paddr = entry_q & ~OFS_MASK_P;
            rsp_mask  = OFS_MASK_A;
            rsp_perm  = entry_q[1:0];
        end else begin
            rsp_iova  = '0;
            rsp_paddr = '0;
            rsp_mask  = '1;
            rsp_perm  = PERM_NONE;
        end
    end

    assign rsp_valid = valid_q;

    xlat_perm_check u_perm (
        .valid    (valid_q),
        .is_write (write_q),
        .perm     (rsp_perm),
        .deny     (rsp_deny),
        .grant    (rsp_grant)
    );

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_IOVA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_iova & OFS_MASK_A) == '0); // R5
    AST_PADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_paddr & OFS_MASK_P) == '0); // R4
    AST_OOR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_range) |=> (rsp_deny && rsp_mask == '1 && rsp_paddr == '0)); // R6
    AST_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_deny && rsp_grant)); // R7
    AST_WRITE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_grant == rsp_perm[1])); // R7
endmodule

// File: tb/iommu_xlat_top_test.sv
module iommu_xlat_top_test;
    localparam int ADDR_W = 32;
    localparam int PA_W = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int NUM_ENTRIES = 48;
    localparam int IDX_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic tbl_wr_en = 1'b0;
    logic [IDX_W-1:0] tbl_wr_idx = '0;
    logic [PA_W-1:0] tbl_wr_data = '0;
    logic rsp_valid;
    logic [ADDR_W-1:0] rsp_iova;
    logic [PA_W-1:0] rsp_paddr;
    logic [ADDR_W-1:0] rsp_mask;
    logic [1:0] rsp_perm;
    logic rsp_deny;
    logic rsp_grant;

    int n_checks = 0;
    int n_fails = 0;

    always #5 clk = ~clk;

    iommu_xlat_top #(
        .ADDR_W(ADDR_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_ENTRIES(NUM_ENTRIES)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_data(tbl_wr_data), .rsp_valid(rsp_valid), .rsp_iova(rsp_iova),
        .rsp_paddr(rsp_paddr), .rsp_mask(rsp_mask), .rsp_perm(rsp_perm),
        .rsp_deny(rsp_deny), .rsp_grant(rsp_grant)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic write_entry(input int idx, input logic [PA_W-1:0] val);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = IDX_W'(idx); tbl_wr_data = val;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // Drives a request at a negedge; result is sampled at the next negedge.
    task automatic lookup(input logic [ADDR_W-1:0] a, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R2", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        write_entry(5, 32'h1234_5003);
        lookup(32'h0000_5000, 1'b0);
        check("R1", "perm before reset", 64'(rsp_perm), 64'd3);
        do_reset();
        lookup(32'h0000_5000, 1'b0);
        check("R1", "perm after reset", 64'(rsp_perm), 64'd0);
        check("R1", "paddr after reset", 64'(rsp_paddr), 64'd0);
        check("R1", "deny after reset", 64'(rsp_deny), 64'd1);
    endtask

    task automatic t_latency();
        write_entry(3, 32'h0000_9001);
        lookup(32'h0000_3010, 1'b0);
        check("R2", "rsp_valid one cycle later", 64'(rsp_valid), 64'd1);
        @(negedge clk);
        check("R2", "rsp_valid drops", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_perm();
        for (int code = 0; code < 4; code++) begin
            write_entry(2, 32'hABCD_E7F0 | 32'(code));
            for (int w = 0; w < 2; w++) begin
                logic exp_ok;
                exp_ok = (w == 1) ? code[1] : code[0];
                lookup(32'h0000_2ABC, w[0]);
                check("R3", "perm code", 64'(rsp_perm), 64'(code));
                check("R7", "deny", 64'(rsp_deny), 64'(!exp_ok));
                check("R7", "grant", 64'(rsp_grant), 64'(exp_ok));
                check("R4", "paddr", 64'(rsp_paddr), 64'hABCD_E000);
                check("R5", "iova", 64'(rsp_iova), 64'h0000_2000);
                check("R5", "mask", 64'(rsp_mask), 64'h0000_0FFF);
            end
        end
    endtask

    task automatic t_range();
        write_entry(0, 32'h7777_7003);
        write_entry(47, 32'h5555_5001);
        lookup(32'h0002_F123, 1'b0);
        check("R6", "last index perm", 64'(rsp_perm), 64'd1);
        check("R6", "last index grant", 64'(rsp_grant), 64'd1);
        lookup(32'h0003_0004, 1'b0);
        check("R6", "idx48 perm", 64'(rsp_perm), 64'd0);
        check("R6", "idx48 mask", 64'(rsp_mask), 64'hFFFF_FFFF);
        check("R6", "idx48 iova", 64'(rsp_iova), 64'd0);
        check("R6", "idx48 deny", 64'(rsp_deny), 64'd1);
        lookup(32'h0004_0000, 1'b1);
        check("R6", "alias idx64 perm", 64'(rsp_perm), 64'd0);
        check("R6", "alias idx64 paddr", 64'(rsp_paddr), 64'd0);
        check("R6", "alias idx64 grant", 64'(rsp_grant), 64'd0);
        check("R6", "alias idx64 mask", 64'(rsp_mask), 64'hFFFF_FFFF);
    endtask

    task automatic t_collide();
        write_entry(7, 32'h1111_1001);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = 6'd7; tbl_wr_data = 32'h2222_2003;
        req_valid = 1'b1; req_addr = 32'h0000_7000; req_write = 1'b1;
        @(negedge clk);
        tbl_wr_en = 1'b0; req_valid = 1'b0;
        check("R8", "collide paddr", 64'(rsp_paddr), 64'h2222_2000);
        check("R8", "collide perm", 64'(rsp_perm), 64'd3);
        lookup(32'h0000_7000, 1'b0);
        check("R8", "later paddr", 64'(rsp_paddr), 64'h2222_2000);
    endtask

    task automatic t_isolate();
        write_entry(10, 32'hAAAA_A001);
        write_entry(11, 32'hBBBB_B002);
        write_entry(10, 32'hCCCC_C003);
        lookup(32'h0000_B000, 1'b1);
        check("R9", "neighbour paddr", 64'(rsp_paddr), 64'hBBBB_B000);
        check("R9", "neighbour perm", 64'(rsp_perm), 64'd2);
        lookup(32'h0000_A000, 1'b1);
        check("R9", "rewritten paddr", 64'(rsp_paddr), 64'hCCCC_C000);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_latency();
                t_perm();
                t_range();
                t_collide();
                t_isolate();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule